// File: doc/BRIEF.md
# Gated random digit generator

This block turns unpredictable human timing into a decimal digit for a reaction game. A decade counter steps on every fast clock, but only while a slow control level is low. That low stretch is the hidden counting phase. When the level goes high the counter freezes, the frozen digit appears on a seven-segment output, and a display-enable is raised. Because the slow level is not related to the fast clock, the number of steps taken in each hidden phase, and so the digit shown, cannot be predicted.

Next to the digit, the block keeps a ten-line one-hot target vector that steps in the same clock. While a digit d is shown, only line d is high, so a player's ten buttons can be gated directly by the target lines. Each time the digit wraps from 9 to 0, the one-hot vector is forced back to line 0, which removes any drift between the two. The slow control level comes from outside the block, and its rate, typically a few hertz, is set there. It is brought into the fast clock domain through a two-stage synchronizer.

Top module: `rand_digit_gate`

## Requirements
- R1: While reset is asserted, and right after it, the segments are all 0, the display-enable is 0 and the target vector is 10'b0000000001 (line 0). The digit is cleared to 0.
- R2: While the synchronized control level is low, the digit advances by one on every clock, modulo 10. A low control pulse that lasts n clocks advances the digit by exactly n mod 10.
- R3: While the synchronized control level is high, the digit and the target vector hold their values on every clock.
- R4: While the synchronized control level is low, the display-enable is 0 and all seven segments are 0.
- R5: While the synchronized control level is high, the display-enable is 1 and the segments, packed as {g,f,e,d,c,b,a} with active-high segments, show the held digit: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F (hex).
- R6: Exactly one target line is high at all times, and its index equals the current digit.
- R7: A step from digit 9 gives digit 0, and the target returns to line 0.
- R8: A change of the control input reaches the block's behaviour after two clock edges. After a rising control input, the display-enable is still 0 after the first edge and is 1 after the second.
- R9: A control low pulse that lasts a single clock still produces exactly one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast counting clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctrl_i | input | 1 | Slow control level, asynchronous: low = hidden counting, high = reveal |
| seg_o | output | 7 | Segments {g,f,e,d,c,b,a}, active high |
| disp_en_o | output | 1 | High while a digit is being shown |
| target_o | output | 10 | One-hot target line for the current digit |

## Verification
Most wrong internal state shows up at the ports within one revealed phase. A miscounting counter gives a digit that differs from the expected (base + n) mod 10 after a low pulse of n clocks. A ring out of step with the counter gives a target index that disagrees with the decoded segments in the same reveal. A synchronizer with the wrong depth moves the display-enable edge off the second clock. A broken wrap shows on the first pulse that crosses 9, where the target must return to line 0.

// File: rtl/rdg_pkg.sv
package rdg_pkg;
  localparam int unsigned RDG_DIGITS = 10;
  localparam int unsigned RDG_DW     = $clog2(RDG_DIGITS);
  localparam int unsigned RDG_SEG_W  = 7;

  typedef logic [RDG_DW-1:0]    digit_t;
  typedef logic [RDG_SEG_W-1:0] seg_t;

  // Active-high segment pattern packed as {g,f,e,d,c,b,a}.
  function automatic seg_t digit_to_seg(input digit_t d);
    seg_t s;
    case (d)
      4'd0:    s = 7'h3F;
      4'd1:    s = 7'h06;
      4'd2:    s = 7'h5B;
      4'd3:    s = 7'h4F;
      4'd4:    s = 7'h66;
      4'd5:    s = 7'h6D;
      4'd6:    s = 7'h7D;
      4'd7:    s = 7'h07;
      4'd8:    s = 7'h7F;
      4'd9:    s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/rdg_rst_sync.sv
module rdg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/rdg_level_sync.sv
module rdg_level_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= {STAGES{RESET_VAL}};
    else         stage_q <= stage_d;
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rdg_decade_cnt.sv
module rdg_decade_cnt
  import rdg_pkg::*;
#(
  parameter int unsigned MODULUS = RDG_DIGITS
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  output digit_t cnt_o,
  output logic   wrap_o
);
  localparam digit_t LAST = digit_t'(MODULUS - 1);

  digit_t cnt_q, cnt_d;
  logic   at_last;

  always_comb begin
    at_last = (cnt_q == LAST);
    cnt_d   = cnt_q;
    if (en_i) begin
      if (at_last) cnt_d = '0;
      else         cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = en_i & at_last;

  assert_digit_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q != LAST) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
  assert_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q == LAST) |=> cnt_q == '0);
endmodule

// File: rtl/rdg_onehot_ring.sv
module rdg_onehot_ring #(
  parameter int unsigned LINES = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             resync_i,
  output logic [LINES-1:0] line_o
);
  localparam logic [LINES-1:0] HOME = LINES'(1);

  logic [LINES-1:0] ring_q, ring_d;

  always_comb begin
    ring_d = ring_q;
    if (resync_i)  ring_d = HOME;
    else if (en_i) ring_d = {ring_q[LINES-2:0], ring_q[LINES-1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ring_q <= HOME;
    else         ring_q <= ring_d;
  end

  assign line_o = ring_q;

  assert_single_line_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ring_q) == 1);
  assert_ring_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !resync_i) |=> $stable(ring_q));
  assert_resync_home_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_i |=> ring_q == HOME);
endmodule

// File: rtl/rdg_seg_drive.sv
module rdg_seg_drive
  import rdg_pkg::*;
(
  input  logic   show_i,
  input  digit_t digit_i,
  output seg_t   seg_o
);
  always_comb begin
    seg_o = '0;
    if (show_i) seg_o = digit_to_seg(digit_i);
  end
endmodule

// File: rtl/rand_digit_gate.sv
module rand_digit_gate
  import rdg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ctrl_i,
  output logic [RDG_SEG_W-1:0] seg_o,
  output logic                 disp_en_o,
  output logic [RDG_DIGITS-1:0] target_o
);
  logic   rst_int_n;
  logic   reveal;
  logic   count_en;
  logic   wrap;
  digit_t digit;
  logic [RDG_DIGITS-1:0] lines;

  rdg_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_int_n)
  );

  rdg_level_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_ctrl_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .d_i    (ctrl_i),
    .q_o    (reveal)
  );

  assign count_en = ~reveal;

  rdg_decade_cnt #(.MODULUS(RDG_DIGITS)) u_digit_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .en_i   (count_en),
    .cnt_o  (digit),
    .wrap_o (wrap)
  );

  rdg_onehot_ring #(.LINES(RDG_DIGITS)) u_target_ring (
    .clk_i    (clk_i),
    .rst_ni   (rst_int_n),
    .en_i     (count_en),
    .resync_i (wrap),
    .line_o   (lines)
  );

  rdg_seg_drive u_seg_drive (
    .show_i  (reveal),
    .digit_i (digit),
    .seg_o   (seg_o)
  );

  assign disp_en_o = reveal;
  assign target_o  = lines;

  assert_target_match_R6: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    lines[digit] == 1'b1);
  assert_blank_when_hidden_R4: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    !disp_en_o |-> seg_o == '0);
  assert_lit_when_shown_R5: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    disp_en_o |-> seg_o != '0);
endmodule

// File: tb/rand_digit_gate_tb.sv
module rand_digit_gate_tb;
  logic       clk;
  logic       rst_n;
  logic       ctrl;
  logic [6:0] seg;
  logic       disp_en;
  logic [9:0] target;

  int checks = 0;
  int errors = 0;
  int base   = 0;

  localparam int NVEC = 12;
  localparam int LOWS [NVEC] = '{1, 2, 3, 5, 9, 10, 11, 17, 20, 37, 4, 100};
  localparam int ADV  [NVEC] = '{1, 2, 3, 5, 9, 0,  1,  7,  0,  7,  4, 0};

  rand_digit_gate u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .ctrl_i    (ctrl),
    .seg_o     (seg),
    .disp_en_o (disp_en),
    .target_o  (target)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [6:0] seg_of(input int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  function automatic int idx_of(input logic [9:0] t);
    int r = -1;
    for (int i = 0; i < 10; i++) if (t[i]) r = i;
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic shown_is(input string req, input int d);
    check({req, " disp_en"}, 32'(disp_en), 32'd1);
    check({req, " seg"}, 32'(seg), 32'(seg_of(d)));
    check({req, " target"}, 32'(target), 32'(10'b1 << d));
  endtask

  // Low pulse of n clocks, driven at negedges; returns after the reveal settles.
  task automatic pulse(input int n, input string req);
    ctrl = 1'b0;
    repeat (n) @(negedge clk);
    ctrl = 1'b1;
    @(negedge clk);
    check({req, " R4 blank en"}, 32'(disp_en), 32'd0);
    check({req, " R4 blank seg"}, 32'(seg), 32'd0);
    @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b1;
    ctrl  = 1'b1;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 seg", 32'(seg), 32'd0);
    check("R1 disp_en", 32'(disp_en), 32'd0);
    check("R1 target", 32'(target), 32'd1);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    base = idx_of(target);
    shown_is("R5 R6 after reset", base);

    // R3: hold while revealed
    repeat (20) @(negedge clk);
    shown_is("R3 hold", base);

    // R8: two-edge latency on the control input
    ctrl = 1'b0;
    repeat (3) @(negedge clk);
    ctrl = 1'b1;
    @(negedge clk);
    check("R8 after one edge", 32'(disp_en), 32'd0);
    @(negedge clk);
    check("R8 after two edges", 32'(disp_en), 32'd1);
    base = (base + 3) % 10;
    shown_is("R8 R2 digit", base);

    // R2 R5 R6 R9: vector table of low-pulse lengths
    for (int v = 0; v < NVEC; v++) begin
      pulse(LOWS[v], "R2");
      base = (base + ADV[v]) % 10;
      shown_is((LOWS[v] == 1) ? "R9 single" : "R2 R5 R6 table", base);
    end

    // R7: step onto 9, then one step wraps to 0 / line 0
    if (base != 9) begin
      pulse(9 - base, "R7 setup");
      base = 9;
    end
    shown_is("R7 at nine", 9);
    pulse(1, "R7");
    base = 0;
    shown_is("R7 wrap", 0);
    check("R7 target home", 32'(target), 32'd1);

    // R1: reset asserted mid-run acts at once
    pulse(4, "R1 setup");
    ctrl = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 mid-run target", 32'(target), 32'd1);
    check("R1 mid-run disp_en", 32'(disp_en), 32'd0);
    check("R1 mid-run seg", 32'(seg), 32'd0);
    ctrl = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    base = idx_of(target);
    shown_is("R6 after second reset", base);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule